// File: doc/BRIEF.md
# Power-up Reset Timing Sequencer

This block keeps a processor core in its internal reset after power is applied and lets it go only when two chained delays have run out. The first delay counts ticks of a slow internal RC timebase and gives the supply time to settle. The second delay counts cycles of the external oscillator and gives a crystal or resonator time to start. An active-low external clear input can hold the core in reset past the end of both delays. It can also force reset at any later time.

Every input is sampled on one system clock. The two timebases arrive as one-cycle tick strobes. The supply monitor is modelled as a digital power-on pulse (`por_i`). This pulse is the only event that starts the full sequence, and it resets all sequencer state asynchronously. A falling supply is not modelled. A wake-from-sleep event re-runs only the oscillator delay, and only when a crystal-type oscillator mode is selected. The supply delay can be removed by a configuration bit. The first delay lasts `PWR_TICKS` ticks, nominally 72 ms of RC timebase. The second delay lasts `OSC_CYCLES` oscillator ticks, 1024 by default.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1 and both done flags are 0. The sequence starts at the first clock edge at which `por_i` is low.
- R2: With `pwr_tmr_en_i` = 1, `pwr_done_o` rises at the clock edge that samples the `PWR_TICKS`-th `rc_tick_i` after the start. `core_rst_o` stays 1 for the whole of this stage.
- R3: With `pwr_tmr_en_i` = 0, the supply stage is skipped and `pwr_done_o` is 1 after the first clock edge following the end of `por_i`.
- R4: The oscillator stage starts only after `pwr_done_o` is set. `osc_tick_i` strobes that arrive earlier are ignored. `osc_done_o` rises at the edge that samples the `OSC_CYCLES`-th `osc_tick_i` of the stage.
- R5: `osc_mode_i` codes are 00 low-power crystal, 01 crystal, 10 high-speed crystal and 11 RC. Only the three crystal codes run the oscillator stage. With code 11, `osc_done_o` is set at the same edge as `pwr_done_o`.
- R6: `core_rst_o` falls one clock after both done flags are set, provided `clr_n_i` is 1. If `clr_n_i` is still 0 at that point, `core_rst_o` falls one clock after `clr_n_i` is sampled high.
- R7: After release, `clr_n_i` = 0 forces `core_rst_o` to 1 combinationally. This does not change either done flag, and `core_rst_o` returns to 0 as soon as `clr_n_i` goes back to 1.
- R8: A `wake_i` strobe after release, in a crystal mode, clears `osc_done_o`, asserts `core_rst_o` and re-runs only the oscillator stage. `pwr_done_o` stays 1 and `rc_tick_i` has no effect. `wake_i` has no effect in RC mode, and no effect before release.
- R9: A new `por_i` pulse at any point clears both flags and both tick counts, and the full sequence then starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous reset of the sequencer |
| clr_n_i | input | 1 | External clear, active low |
| pwr_tmr_en_i | input | 1 | 1 runs the supply-settle stage, 0 skips it |
| osc_mode_i | input | 2 | Oscillator mode: 00/01/10 crystal types, 11 RC |
| wake_i | input | 1 | One-cycle wake-from-sleep strobe |
| rc_tick_i | input | 1 | One-cycle tick from the internal RC timebase |
| osc_tick_i | input | 1 | One-cycle tick per external oscillator cycle |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| pwr_done_o | output | 1 | Supply-settle stage finished |
| osc_done_o | output | 1 | Oscillator start-up stage finished |

## Verification
The bench sweeps all eight combinations of stage enable and oscillator mode through a full power-up. In each one it feeds ticks of the wrong timebase during each stage. A design that let oscillator ticks count early, or that counted RC ticks in the oscillator stage, would release reset too soon. The bench restarts power-on in the middle of a partly counted stage. A counter that was not cleared would then finish the next run early. It also sends wake strobes in RC mode, in crystal modes and during the supply stage. A design that re-ran the supply stage, ignored the mode, or let a wake strobe disturb the count would show a wrong reset or flag value. Finally, it holds the external clear low past the end of both timers and pulses it after release. This exposes a release that ignores the clear input, and a clear that restarts the timers.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_PWR_RUN   = 3'd1,
      ST_OSC_RUN   = 3'd2,
      ST_WAIT_CLR  = 3'd3,
      ST_RUN       = 3'd4
   } seq_state_t;

   localparam logic [1:0] OSC_LOWPWR_XTAL = 2'b00;
   localparam logic [1:0] OSC_XTAL        = 2'b01;
   localparam logic [1:0] OSC_HISPD_XTAL  = 2'b10;
   localparam logic [1:0] OSC_RC          = 2'b11;

   // crystal-type sources need the start-up wait, RC does not
   function automatic logic needs_osc_wait(input logic [1:0] mode);
      return (mode != OSC_RC);
   endfunction

endpackage

// File: rtl/pwrup_stage_timer.sv
module pwrup_stage_timer #(
   parameter int unsigned COUNT = 72
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic run_i,
   input  logic tick_i,
   output logic expire_o
);

   localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1;

   initial begin
      assert (COUNT >= 1) else $fatal(1, "pwrup_stage_timer: COUNT must be at least 1");
   end

   generate
      if (COUNT == 1) begin : g_single
         // one tick is the whole delay: no storage needed
         assign expire_o = run_i & tick_i;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(COUNT - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i or posedge por_i) begin
            if (por_i)
               cnt_q <= '0;
            else if (!run_i)
               cnt_q <= '0;               // cleared whenever the stage is not active
            else if (tick_i)
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end

         assign expire_o = run_i & tick_i & (cnt_q == LAST);

         // R2/R4: the count never passes the terminal value
         a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (por_i)
            cnt_q <= LAST);

         // R4: without a tick an active stage keeps its count
         a_r4_cnt_holds: assert property (@(posedge clk_i) disable iff (por_i)
            (run_i && !tick_i) |=> (cnt_q == $past(cnt_q)));

         // R9: an idle stage starts from zero next time
         a_r9_cnt_cleared: assert property (@(posedge clk_i) disable iff (por_i)
            !run_i |=> (cnt_q == '0));
      end
   endgenerate

endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
   import pwrup_pkg::*;
(
   input  logic       clk_i,
   input  logic       por_i,
   input  logic       clr_n_i,
   input  logic       pwr_tmr_en_i,
   input  logic [1:0] osc_mode_i,
   input  logic       wake_i,
   input  logic       pwr_expire_i,
   input  logic       osc_expire_i,
   output logic       pwr_run_o,
   output logic       osc_run_o,
   output logic       pwr_done_o,
   output logic       osc_done_o,
   output logic       core_rst_o
);

   seq_state_t state_q, state_d;
   logic       pwr_done_q, pwr_done_d;
   logic       osc_done_q, osc_done_d;
   logic       xtal_mode;

   assign xtal_mode = needs_osc_wait(osc_mode_i);

   always_comb begin
      state_d    = state_q;
      pwr_done_d = pwr_done_q;
      osc_done_d = osc_done_q;
      unique case (state_q)
         ST_IDLE: begin
            if (pwr_tmr_en_i) begin
               state_d = ST_PWR_RUN;
            end else begin
               pwr_done_d = 1'b1;
               if (xtal_mode) begin
                  state_d = ST_OSC_RUN;
               end else begin
                  osc_done_d = 1'b1;
                  state_d    = ST_WAIT_CLR;
               end
            end
         end
         ST_PWR_RUN: begin
            if (pwr_expire_i) begin
               pwr_done_d = 1'b1;
               if (xtal_mode) begin
                  state_d = ST_OSC_RUN;
               end else begin
                  osc_done_d = 1'b1;
                  state_d    = ST_WAIT_CLR;
               end
            end
         end
         ST_OSC_RUN: begin
            if (osc_expire_i) begin
               osc_done_d = 1'b1;
               state_d    = ST_WAIT_CLR;
            end
         end
         ST_WAIT_CLR: begin
            if (clr_n_i) state_d = ST_RUN;
         end
         ST_RUN: begin
            if (wake_i && xtal_mode) begin
               osc_done_d = 1'b0;
               state_d    = ST_OSC_RUN;
            end
         end
         default: begin
            state_d    = ST_IDLE;
            pwr_done_d = 1'b0;
            osc_done_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         state_q    <= ST_IDLE;
         pwr_done_q <= 1'b0;
         osc_done_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         pwr_done_q <= pwr_done_d;
         osc_done_q <= osc_done_d;
      end
   end

   assign pwr_run_o  = (state_q == ST_PWR_RUN);
   assign osc_run_o  = (state_q == ST_OSC_RUN);
   assign pwr_done_o = pwr_done_q;
   assign osc_done_o = osc_done_q;
   assign core_rst_o = (state_q != ST_RUN) | ~clr_n_i;

   // R4: the oscillator stage never finishes ahead of the supply stage
   a_r4_stage_order: assert property (@(posedge clk_i) disable iff (por_i)
      osc_done_q |-> pwr_done_q);

   // R6: release only with both stages done and clear high
   a_r6_release_needs_all: assert property (@(posedge clk_i) disable iff (por_i)
      !core_rst_o |-> (pwr_done_q && osc_done_q && clr_n_i));

   // R5: in RC mode both flags appear together
   a_r5_rc_same_edge: assert property (@(posedge clk_i) disable iff (por_i)
      ($rose(pwr_done_q) && osc_mode_i == OSC_RC) |-> osc_done_q);

   // R8: a wake in a crystal mode reruns only the oscillator stage
   a_r8_wake_rerun: assert property (@(posedge clk_i) disable iff (por_i)
      (state_q == ST_RUN && wake_i && xtal_mode) |=>
         (state_q == ST_OSC_RUN && !osc_done_q && pwr_done_q));

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq #(
   parameter int unsigned PWR_TICKS  = 72,
   parameter int unsigned OSC_CYCLES = 1024
) (
   input  logic       clk_i,
   input  logic       por_i,
   input  logic       clr_n_i,
   input  logic       pwr_tmr_en_i,
   input  logic [1:0] osc_mode_i,
   input  logic       wake_i,
   input  logic       rc_tick_i,
   input  logic       osc_tick_i,
   output logic       core_rst_o,
   output logic       pwr_done_o,
   output logic       osc_done_o
);

   initial begin
      assert (PWR_TICKS >= 1)  else $fatal(1, "pwrup_rst_seq: PWR_TICKS must be at least 1");
      assert (OSC_CYCLES >= 1) else $fatal(1, "pwrup_rst_seq: OSC_CYCLES must be at least 1");
   end

   logic pwr_run, osc_run, pwr_expire, osc_expire;

   pwrup_stage_timer #(.COUNT(PWR_TICKS)) i_pwr_timer (
      .clk_i    (clk_i),
      .por_i    (por_i),
      .run_i    (pwr_run),
      .tick_i   (rc_tick_i),
      .expire_o (pwr_expire)
   );

   pwrup_stage_timer #(.COUNT(OSC_CYCLES)) i_osc_timer (
      .clk_i    (clk_i),
      .por_i    (por_i),
      .run_i    (osc_run),
      .tick_i   (osc_tick_i),
      .expire_o (osc_expire)
   );

   pwrup_seq_fsm i_fsm (
      .clk_i        (clk_i),
      .por_i        (por_i),
      .clr_n_i      (clr_n_i),
      .pwr_tmr_en_i (pwr_tmr_en_i),
      .osc_mode_i   (osc_mode_i),
      .wake_i       (wake_i),
      .pwr_expire_i (pwr_expire),
      .osc_expire_i (osc_expire),
      .pwr_run_o    (pwr_run),
      .osc_run_o    (osc_run),
      .pwr_done_o   (pwr_done_o),
      .osc_done_o   (osc_done_o),
      .core_rst_o   (core_rst_o)
   );

   // R1: power-on holds the core and clears status
   a_r1_por_holds: assert property (@(posedge clk_i)
      por_i |-> (core_rst_o && !pwr_done_o && !osc_done_o));

   // R7: external clear low always means reset
   a_r7_clear_forces: assert property (@(posedge clk_i) disable iff (por_i)
      !clr_n_i |-> core_rst_o);

   // R2: no supply-stage expiry while that stage is idle
   a_r2_expire_in_stage: assert property (@(posedge clk_i) disable iff (por_i)
      pwr_expire |-> !pwr_done_o);

endmodule

// File: tb/test_pwrup_rst_seq.sv
module test_pwrup_rst_seq;

   localparam int unsigned PWR = 5;
   localparam int unsigned OSC = 8;

   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       clr_n = 1'b1;
   logic       en = 1'b1;
   logic [1:0] mode = 2'b00;
   logic       wake = 1'b0;
   logic       rc_tick = 1'b0;
   logic       osc_tick = 1'b0;
   logic       core_rst, pwr_done, osc_done;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwrup_rst_seq #(.PWR_TICKS(PWR), .OSC_CYCLES(OSC)) i_pwrup_rst_seq (
      .clk_i(clk), .por_i(por), .clr_n_i(clr_n), .pwr_tmr_en_i(en),
      .osc_mode_i(mode), .wake_i(wake), .rc_tick_i(rc_tick),
      .osc_tick_i(osc_tick), .core_rst_o(core_rst),
      .pwr_done_o(pwr_done), .osc_done_o(osc_done)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse_rc();
      rc_tick = 1'b1; @(negedge clk); rc_tick = 1'b0;
   endtask

   task automatic pulse_osc();
      osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
   endtask

   task automatic pulse_wake();
      wake = 1'b1; @(negedge clk); wake = 1'b0;
   endtask

   // R1: pulse power-on, check held state, release, pass the first edge
   task automatic start_por();
      por = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 rst during por", core_rst, 1'b1);
      check("R1 pwr_done during por", pwr_done, 1'b0);
      check("R1 osc_done during por", osc_done, 1'b0);
      por = 1'b0;
      @(negedge clk);
   endtask

   // R2: supply stage with stray oscillator ticks (R4)
   task automatic run_pwr();
      for (int i = 0; i < int'(PWR); i++) begin
         check("R2 rst held in supply stage", core_rst, 1'b1);
         check("R2 pwr_done early", pwr_done, 1'b0);
         pulse_osc();
         check("R4 osc tick ignored early", osc_done, 1'b0);
         pulse_rc();
      end
      check("R2 pwr_done after last tick", pwr_done, 1'b1);
   endtask

   // R4: oscillator stage with stray RC ticks
   task automatic run_osc();
      for (int i = 0; i < int'(OSC); i++) begin
         check("R4 rst held in osc stage", core_rst, 1'b1);
         check("R4 osc_done early", osc_done, 1'b0);
         pulse_rc();
         pulse_osc();
      end
      check("R4 osc_done after last tick", osc_done, 1'b1);
      check("R4 pwr_done kept", pwr_done, 1'b1);
   endtask

   // R6: one cycle in the wait state, then release
   task automatic finish_release();
      check("R6 rst one cycle after done", core_rst, 1'b1);
      @(negedge clk);
      check("R6 rst released", core_rst, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      // sweep: stage enable x oscillator mode, with wake behaviour
      for (int e = 0; e < 2; e++) begin
         for (int m = 0; m < 4; m++) begin
            en   = e[0];
            mode = m[1:0];
            start_por();
            if (e == 1) run_pwr();
            else        check("R3 stage skipped", pwr_done, 1'b1);
            if (m != 3) run_osc();
            else        check("R5 rc mode osc done with supply", osc_done, 1'b1);
            finish_release();
            pulse_wake();
            if (m != 3) begin
               check("R8 wake asserts rst", core_rst, 1'b1);
               check("R8 wake clears osc_done", osc_done, 1'b0);
               check("R8 wake keeps pwr_done", pwr_done, 1'b1);
               run_osc();
               finish_release();
            end else begin
               check("R8 wake ignored in rc mode rst", core_rst, 1'b0);
               check("R8 wake ignored in rc mode flag", osc_done, 1'b1);
            end
         end
      end

      // R6: clear held low past both timers
      en = 1'b1; mode = 2'b01; clr_n = 1'b0;
      start_por();
      run_pwr();
      run_osc();
      repeat (4) begin
         @(negedge clk);
         check("R6 rst held by clear", core_rst, 1'b1);
      end
      clr_n = 1'b1;
      #1 check("R6 rst still held in wait", core_rst, 1'b1);
      @(negedge clk);
      check("R6 rst released after clear", core_rst, 1'b0);

      // R7: clear pulse after release
      clr_n = 1'b0;
      #1 check("R7 clear asserts rst at once", core_rst, 1'b1);
      repeat (3) @(negedge clk);
      check("R7 pwr_done kept", pwr_done, 1'b1);
      check("R7 osc_done kept", osc_done, 1'b1);
      clr_n = 1'b1;
      #1 check("R7 rst drops with clear", core_rst, 1'b0);
      @(negedge clk);

      // R9: restart in the middle of the oscillator stage
      start_por();
      run_pwr();
      repeat (3) pulse_osc();
      start_por();
      check("R9 pwr_done cleared", pwr_done, 1'b0);
      run_pwr();
      run_osc();
      finish_release();

      // R9: restart in the middle of the supply stage
      start_por();
      repeat (3) pulse_rc();
      start_por();
      run_pwr();
      run_osc();
      finish_release();

      // R8: wake during the supply stage changes nothing
      start_por();
      repeat (2) pulse_rc();
      pulse_wake();
      repeat (int'(PWR) - 3) pulse_rc();
      check("R8 wake in stage no early done", pwr_done, 1'b0);
      pulse_rc();
      check("R8 wake in stage done on time", pwr_done, 1'b1);
      run_osc();
      finish_release();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule